// File: doc/BRIEF.md
# Fast Interrupt Source Selector

This block picks a single interrupt source and drives it onto a dedicated fast-interrupt output. There are 72 raw level inputs in three groups: a 32-line first peripheral bank, a 32-line second peripheral bank and an 8-line basic group. Software chooses the source by writing one control word on a simple register port. The word holds a 7-bit flat source number and an arm bit. The flat numbering starts with the first peripheral bank, then the second, then the basic group. Numbers past the last real source select nothing.

The output is the arm bit ANDed with the live level of the chosen source. The only register in the path is the control word, so a change on a source input reaches the output without a clock. The selector does not mask the source on the normal interrupt path. Software should disable that source there before arming it, or both interrupt lines will assert together. Writing zero to the control word disarms the output.

Top module: `fiq_sel`

## Requirements
- R1: While `rst_ni` is low and after reset, the control word is 0, `fiq_o` is low and a read of the control offset returns 0.
- R2: A write with `bus_we_i` high at byte offset 0x0C stores `bus_wdata_i[7:0]` on that clock edge. A later read of 0x0C returns those 8 bits in `bus_rdata_o[7:0]`, with bits 31:8 reading as 0. Bit 7 is the arm bit and bits 6:0 are the flat source number.
- R3: A write to any offset other than 0x0C leaves the control word unchanged.
- R4: When armed with a source number from 0 to 31, `fiq_o` follows `bank1_i[n]`.
- R5: When armed with a source number from 32 to 63, `fiq_o` follows `bank2_i[n-32]`.
- R6: When armed with a source number from 64 to 71, `fiq_o` follows `basic_i[n-64]`.
- R7: When armed with a source number from 72 to 127, `fiq_o` stays low whatever the source inputs are.
- R8: When the arm bit is 0, `fiq_o` stays low whatever the source number and source inputs are. This includes the all-zero control word.
- R9: `fiq_o` responds to a change on the selected source input in the same cycle, with no clock edge in between.
- R10: A read at any offset other than 0x0C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Byte offset used for both read and write |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset (combinational) |
| bank1_i | input | 32 | First peripheral bank levels, flat numbers 0-31 |
| bank2_i | input | 32 | Second peripheral bank levels, flat numbers 32-63 |
| basic_i | input | 8 | Basic group levels, flat numbers 64-71 |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The hardest cases to reach are the edges between groups in the flat numbering, where an off-by-one mapping or an offset applied to the wrong group would pass any test that stays inside one group.

The stimulus arms each boundary number: 31, 32, 63, 64, 71 and 72. At each one it drives a single hot input, so the output is high only if the mapping is exact. It also arms numbers past the end with every input high, to show that nothing leaks through.

Writes to a neighbouring offset are mixed in, followed by reads at both offsets. These show that the control word survives stray writes.

// File: rtl/fiq_sel_pkg.sv
package fiq_sel_pkg;
  localparam int unsigned SRC_IDX_W = 7;
  localparam int unsigned CTRL_W    = SRC_IDX_W + 1;

  typedef struct packed {
    logic                 arm;
    logic [SRC_IDX_W-1:0] src;
  } fiq_ctrl_t;
endpackage

// File: rtl/fiq_sel_ctrl.sv
module fiq_sel_ctrl
  import fiq_sel_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output fiq_ctrl_t         ctrl_o
);
  logic hit;
  fiq_ctrl_t ctrl_q;

  assign hit = (bus_addr_i == CTRL_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ctrl_q <= '0;
    else if (bus_we_i && hit) ctrl_q <= fiq_ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit) bus_rdata_o[CTRL_W-1:0] = ctrl_q;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/fiq_sel_mux.sv
module fiq_sel_mux
  import fiq_sel_pkg::*;
#(
  parameter int unsigned N_BANK1 = 32,
  parameter int unsigned N_BANK2 = 32,
  parameter int unsigned N_BASIC = 8
) (
  input  logic [N_BANK1-1:0] bank1_i,
  input  logic [N_BANK2-1:0] bank2_i,
  input  logic [N_BASIC-1:0] basic_i,
  input  fiq_ctrl_t          ctrl_i,
  output logic               fiq_o
);
  localparam int unsigned N_SRC = N_BANK1 + N_BANK2 + N_BASIC;
  localparam int unsigned SPAN  = 1 << SRC_IDX_W;

  logic [N_SRC-1:0] flat;
  logic [SPAN-1:0]  span_vec;
  logic             lvl;

  // flat order: bank1 lowest, then bank2, then basic
  assign flat = {basic_i, bank2_i, bank1_i};

  generate
    if (N_SRC < SPAN) begin : g_pad
      assign span_vec = {{(SPAN - N_SRC){1'b0}}, flat};
    end else begin : g_fit
      assign span_vec = flat[SPAN-1:0];
    end
  endgenerate

  assign lvl   = span_vec[ctrl_i.src];
  assign fiq_o = ctrl_i.arm & lvl;
endmodule

// File: rtl/fiq_sel.sv
module fiq_sel
  import fiq_sel_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h0C,
  parameter int unsigned N_BANK1  = 32,
  parameter int unsigned N_BANK2  = 32,
  parameter int unsigned N_BASIC  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [N_BANK1-1:0] bank1_i,
  input  logic [N_BANK2-1:0] bank2_i,
  input  logic [N_BASIC-1:0] basic_i,
  output logic               fiq_o
);
  fiq_ctrl_t ctrl_q;

  fiq_sel_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .ctrl_o(ctrl_q)
  );

  fiq_sel_mux #(
    .N_BANK1(N_BANK1), .N_BANK2(N_BANK2), .N_BASIC(N_BASIC)
  ) u_mux (
    .bank1_i(bank1_i), .bank2_i(bank2_i), .basic_i(basic_i),
    .ctrl_i(ctrl_q), .fiq_o(fiq_o)
  );
endmodule

// File: rtl/fiq_sel_chk.sv
module fiq_sel_chk
  import fiq_sel_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h0C,
  parameter int unsigned N_SRC    = 72
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input fiq_ctrl_t         ctrl_q,
  input logic              fiq_o
);
  a_r8_disarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.arm |-> !fiq_o);

  a_r7_unmapped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(ctrl_q.src) >= N_SRC) |-> !fiq_o);

  a_r2_write_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == CTRL_OFS) |=> (ctrl_q == $past(bus_wdata_i[CTRL_W-1:0])));

  a_r3_foreign_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i != CTRL_OFS) |=> $stable(ctrl_q));

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:CTRL_W] == '0);

  a_r10_foreign_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != CTRL_OFS) |-> (bus_rdata_o == '0));
endmodule

bind fiq_sel fiq_sel_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS),
  .N_SRC(N_BANK1 + N_BANK2 + N_BASIC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .ctrl_q(ctrl_q), .fiq_o(fiq_o)
);

// File: tb/fiq_sel_tb.sv
module fiq_sel_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bus_addr = 8'h0C;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] bank1 = '0;
  logic [31:0] bank2 = '0;
  logic [7:0]  basic = '0;
  logic        fiq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        fiq;
    logic [31:0] rdata;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;

  always #5 clk = ~clk;

  fiq_sel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bank1_i(bank1), .bank2_i(bank2), .basic_i(basic), .fiq_o(fiq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h0C;
  endtask

  task automatic expect_now(input logic f, input logic [31:0] r, input string tag);
    exp_t e;
    e.fiq = f; e.rdata = r; e.tag = tag;
    sb_q.push_back(e);
    #1 -> chk_ev;
    #3;
  endtask

  task automatic set_src(input logic [31:0] b1, input logic [31:0] b2, input logic [7:0] b0);
    bank1 = b1; bank2 = b2; basic = b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (fiq !== e.fiq || bus_rdata !== e.rdata) begin
          errors++;
          $display("FAIL %s: fiq=%0b rdata=%h expected fiq=%0b rdata=%h",
                   e.tag, fiq, bus_rdata, e.fiq, e.rdata);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    set_src('1, '1, '1);
    expect_now(1'b0, 32'h0, "R1 in reset");
    set_src('0, '0, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    expect_now(1'b0, 32'h0, "R1 after reset");

    wr(8'h0C, 32'h0000_0085);
    set_src(32'h0000_0020, '0, '0);
    expect_now(1'b1, 32'h85, "R4 src5 + R2 readback");
    bank1 = '0;
    expect_now(1'b0, 32'h85, "R9 same-cycle drop");
    bank1[5] = 1'b1;
    expect_now(1'b1, 32'h85, "R9 same-cycle rise");

    wr(8'h0C, 32'hFFFF_FF9F);
    set_src(32'h8000_0000, 32'h0000_0001, '0);
    expect_now(1'b1, 32'h9F, "R4 src31 + R2 upper zero");
    set_src(32'h7FFF_FFFF, 32'h0000_0001, '0);
    expect_now(1'b0, 32'h9F, "R4 src31 neighbours only");

    wr(8'h0C, 32'h0000_00A0);
    set_src(32'h8000_0000, 32'h0000_0001, '0);
    expect_now(1'b1, 32'hA0, "R5 src32");
    set_src(32'hFFFF_FFFF, 32'h0000_0002, '0);
    expect_now(1'b0, 32'hA0, "R5 src32 not bank1");

    wr(8'h0C, 32'h0000_00BF);
    set_src('0, 32'h8000_0000, 8'h01);
    expect_now(1'b1, 32'hBF, "R5 src63");

    wr(8'h0C, 32'h0000_00C0);
    expect_now(1'b1, 32'hC0, "R6 src64");
    set_src('0, 32'h8000_0000, 8'hFE);
    expect_now(1'b0, 32'hC0, "R6 src64 isolated");

    wr(8'h0C, 32'h0000_00C7);
    set_src('0, '0, 8'h80);
    expect_now(1'b1, 32'hC7, "R6 src71");

    wr(8'h0C, 32'h0000_00C8);
    set_src('1, '1, '1);
    expect_now(1'b0, 32'hC8, "R7 src72");
    wr(8'h0C, 32'h0000_00FF);
    expect_now(1'b0, 32'hFF, "R7 src127");

    wr(8'h0C, 32'h0000_0005);
    expect_now(1'b0, 32'h05, "R8 disarmed src5");
    wr(8'h0C, 32'h0000_0000);
    expect_now(1'b0, 32'h00, "R8 zero word");

    wr(8'h0C, 32'h0000_0085);
    wr(8'h08, 32'h0000_0000);
    wr(8'h0D, 32'h0000_00C8);
    expect_now(1'b1, 32'h85, "R3 foreign writes ignored");
    bus_addr = 8'h08;
    expect_now(1'b1, 32'h0, "R10 read other offset");
    bus_addr = 8'h10;
    expect_now(1'b1, 32'h0, "R10 read offset 0x10");
    bus_addr = 8'h0C;

    #10;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule